// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Selective Overflow

This block is the arithmetic slice of a small RISC datapath. It adds or subtracts two register operands, or adds a register and a sign-extended immediate. It returns the wrapped result together with a signed-overflow flag. The unit has no clock: the outputs follow the inputs within the same cycle, and the surrounding pipeline registers them.

Each operation comes in two forms. The checked form reports two's-complement overflow. The unchecked form produces exactly the same result bits and keeps the flag low. There is no subtract-immediate form. A constant is subtracted by adding its negative through the immediate path, so a negative immediate has to sign-extend correctly.

The unit also qualifies the register-file write. When the datapath requests a write and a checked operation overflows, the write is withheld, so the destination register keeps its old value. An opcode outside the defined set produces a zero result, no flag and no write.

Top module: `addsub_unit`

## Requirements
- R1: Opcode 3'd0 (checked add) and opcode 3'd1 (unchecked add) produce `rs_a_i + rs_b_i` modulo 2^W.
- R2: Opcode 3'd2 (checked subtract) and opcode 3'd3 (unchecked subtract) produce `rs_a_i - rs_b_i` modulo 2^W, formed as A + ~B + 1.
- R3: Opcode 3'd4 (checked add-immediate) and opcode 3'd5 (unchecked add-immediate) produce `rs_a_i` plus `imm_i` sign-extended from IW bits to W bits. In these modes `rs_b_i` has no effect.
- R4: For the unchecked opcodes (bit 0 of the opcode set, opcodes 1, 3 and 5), `ovf_o` is always 0.
- R5: For opcodes 0 and 4, `ovf_o` is 1 exactly when the two addends have the same sign and the sign of the result differs from them.
- R6: For opcode 2, `ovf_o` is 1 exactly when the operands differ in sign and the sign of the result differs from the sign of `rs_a_i`.
- R7: For a defined opcode, `wr_en_o` equals `wr_req_i` AND NOT `ovf_o`.
- R8: Opcodes 3'd6 and 3'd7 are undefined. For these, `result_o` is 0, `ovf_o` is 0 and `wr_en_o` is 0.
- R9: A checked opcode and its unchecked counterpart return identical `result_o` for the same operands, including when the checked form overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation select: bit 0 = unchecked, bit 1 = subtract, bit 2 = immediate |
| rs_a_i | input | W | First register operand |
| rs_b_i | input | W | Second register operand (used by the register forms only) |
| imm_i | input | IW | Signed immediate, used by the immediate forms |
| wr_req_i | input | 1 | The datapath intends to write the destination |
| result_o | output | W | Wrapped sum or difference |
| ovf_o | output | 1 | Signed overflow, checked forms only |
| wr_en_o | output | 1 | Qualified register-file write enable |

## Verification
The bench sweeps a 4-bit instance with a 3-bit immediate over every opcode, every operand pair and every immediate. Against it, the bench computes the true signed result as an integer and tests whether it fits in the range. This exposes the following faults:
- A subtract that forgets the +1 gives results that are off by one.
- An immediate that is zero-extended makes a negative constant add a large positive value.
- An overflow test that uses the carry-out flags unsigned wraps as overflow.
- A subtract overflow that compares the result with the wrong operand misses the most-negative cases.

Directed 32-bit cases then cover the most-positive plus one and the most-negative minus one. They also cover the difference zero minus the most-negative value and an add-immediate of -10. In each case the bench confirms that the unchecked form keeps the same bits and raises no flag, and that an overflowing checked form drops the write.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam logic [2:0] OP_ADD   = 3'd0;
  localparam logic [2:0] OP_ADDU  = 3'd1;
  localparam logic [2:0] OP_SUB   = 3'd2;
  localparam logic [2:0] OP_SUBU  = 3'd3;
  localparam logic [2:0] OP_ADDI  = 3'd4;
  localparam logic [2:0] OP_ADDIU = 3'd5;

  typedef struct packed {
    logic valid;
    logic use_imm;
    logic is_sub;
    logic checked;
  } op_ctl_t;

  // Opcode bits: [0] unchecked, [1] subtract, [2] immediate; imm+sub is undefined.
  function automatic op_ctl_t decode_op(input logic [2:0] op);
    op_ctl_t c;
    c.valid   = !(op[2] && op[1]);
    c.use_imm = op[2];
    c.is_sub  = op[1];
    c.checked = !op[0];
    return c;
  endfunction

endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [W-1:0]  rs_b,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  output logic [W-1:0]  opnd_b
);

  logic [W-1:0] imm_ext;

  generate
    if (IW < W) begin : g_extend
      assign imm_ext = {{(W-IW){imm[IW-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[W-1:0];
    end
  endgenerate

  assign opnd_b = use_imm ? imm_ext : rs_b;

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  output logic [W-1:0] sum
);

  // One shared adder: subtraction feeds the inverted operand and a carry-in of 1.
  function automatic logic [W-1:0] add_core(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic         cin);
    return x + (y ^ {W{cin}}) + {{(W-1){1'b0}}, cin};
  endfunction

  assign sum = add_core(a, b, is_sub);

endmodule

// File: rtl/addsub_ovf_detect.sv
module addsub_ovf_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] sum,
  input  logic         is_sub,
  output logic         ovf_raw
);

  function automatic logic sign_ovf(input logic sa, input logic sb,
                                    input logic sr, input logic sub);
    logic same_dir;
    same_dir = sub ? (sa != sb) : (sa == sb);
    return same_dir && (sr != sa);
  endfunction

  assign ovf_raw = sign_ovf(a[W-1], b[W-1], sum[W-1], is_sub);

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  rs_a_i,
  input  logic [W-1:0]  rs_b_i,
  input  logic [IW-1:0] imm_i,
  input  logic          wr_req_i,
  output logic [W-1:0]  result_o,
  output logic          ovf_o,
  output logic          wr_en_o
);

  op_ctl_t      ctl;
  logic         op_valid;
  logic [W-1:0] opnd_b;
  logic [W-1:0] raw_sum;
  logic         ovf_raw;

  assign ctl      = decode_op(op_i);
  assign op_valid = ctl.valid;

  addsub_operand_sel #(.W(W), .IW(IW)) u_sel (
    .rs_b    (rs_b_i),
    .imm     (imm_i),
    .use_imm (ctl.use_imm),
    .opnd_b  (opnd_b)
  );

  addsub_adder #(.W(W)) u_add (
    .a      (rs_a_i),
    .b      (opnd_b),
    .is_sub (ctl.is_sub),
    .sum    (raw_sum)
  );

  addsub_ovf_detect #(.W(W)) u_ovf (
    .a       (rs_a_i),
    .b       (opnd_b),
    .sum     (raw_sum),
    .is_sub  (ctl.is_sub),
    .ovf_raw (ovf_raw)
  );

  assign result_o = op_valid ? raw_sum : '0;
  assign ovf_o    = op_valid && ctl.checked && ovf_raw;
  assign wr_en_o  = op_valid && wr_req_i && !ovf_o;

endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input logic [2:0]    op_i,
  input logic [W-1:0]  rs_a_i,
  input logic [W-1:0]  rs_b_i,
  input logic [IW-1:0] imm_i,
  input logic          wr_req_i,
  input logic          op_valid,
  input logic [W-1:0]  opnd_b,
  input logic [W-1:0]  result_o,
  input logic          ovf_o,
  input logic          wr_en_o
);

  logic [W-1:0] imm_ext_chk;
  assign imm_ext_chk = W'($signed(imm_i));

  always_comb begin
    if (op_i == 3'd0 || op_i == 3'd1)
      assert_add_result_R1: assert (result_o - rs_b_i == rs_a_i);
    if (op_i == 3'd2 || op_i == 3'd3)
      assert_sub_result_R2: assert (result_o + rs_b_i == rs_a_i);
    if (op_i == 3'd4 || op_i == 3'd5) begin
      assert_imm_operand_R3: assert (opnd_b == imm_ext_chk);
      assert_imm_result_R3: assert (result_o - imm_ext_chk == rs_a_i);
    end
    if (op_valid && op_i[0])
      assert_no_overflow_R4: assert (!ovf_o);
    if (op_i == 3'd0)
      assert_add_ovf_R5: assert (ovf_o == ((rs_a_i[W-1] == rs_b_i[W-1]) &&
                                           (result_o[W-1] != rs_a_i[W-1])));
    if (op_i == 3'd2)
      assert_sub_ovf_R6: assert (ovf_o == ((rs_a_i[W-1] != rs_b_i[W-1]) &&
                                           (result_o[W-1] != rs_a_i[W-1])));
    if (op_valid)
      assert_write_gate_R7: assert (wr_en_o == (wr_req_i && !ovf_o));
    if (!op_valid)
      assert_undefined_quiet_R8: assert (result_o == '0 && !ovf_o && !wr_en_o);
  end

endmodule

bind addsub_unit addsub_checker #(.W(W), .IW(IW)) u_chk (
  .op_i     (op_i),
  .rs_a_i   (rs_a_i),
  .rs_b_i   (rs_b_i),
  .imm_i    (imm_i),
  .wr_req_i (wr_req_i),
  .op_valid (op_valid),
  .opnd_b   (opnd_b),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .wr_en_o  (wr_en_o)
);

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW  = 4;
  localparam int SIW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // small sweep instance
  logic [2:0]     s_op = '0;
  logic [SW-1:0]  s_a = '0, s_b = '0;
  logic [SIW-1:0] s_imm = '0;
  logic           s_req = 1'b0;
  logic [SW-1:0]  s_res;
  logic           s_ovf, s_wr;

  addsub_unit #(.W(SW), .IW(SIW)) u_dut (
    .op_i(s_op), .rs_a_i(s_a), .rs_b_i(s_b), .imm_i(s_imm), .wr_req_i(s_req),
    .result_o(s_res), .ovf_o(s_ovf), .wr_en_o(s_wr)
  );

  // full-width instance
  logic [2:0]  w_op = '0;
  logic [31:0] w_a = '0, w_b = '0;
  logic [15:0] w_imm = '0;
  logic        w_req = 1'b0;
  logic [31:0] w_res;
  logic        w_ovf, w_wr;

  addsub_unit #(.W(32), .IW(16)) u_dut_w (
    .op_i(w_op), .rs_a_i(w_a), .rs_b_i(w_b), .imm_i(w_imm), .wr_req_i(w_req),
    .result_o(w_res), .ovf_o(w_ovf), .wr_en_o(w_wr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  function automatic int sx(input int v, input int bits);
    return (v >= (1 << (bits-1))) ? v - (1 << bits) : v;
  endfunction

  task automatic small_vec(input int op, input int a, input int b, input int imm, input bit req);
    int opb, tru, eres;
    bit valid, chkd, eovf, ewr;
    string rtag, otag;
    @(posedge clk);
    s_op = 3'(op); s_a = SW'(a); s_b = SW'(b); s_imm = SIW'(imm); s_req = req;
    @(negedge clk);
    valid = (op < 6);
    chkd  = (op[0] == 1'b0);
    opb   = (op >= 4) ? sx(imm, SIW) : sx(b, SW);
    tru   = op[1] ? sx(a, SW) - opb : sx(a, SW) + opb;
    eres  = valid ? (tru & ((1 << SW) - 1)) : 0;
    eovf  = valid && chkd && (tru > (1 << (SW-1)) - 1 || tru < -(1 << (SW-1)));
    ewr   = valid && req && !eovf;
    rtag  = !valid ? "R8" : (op >= 4) ? "R3" : op[1] ? "R2" : "R1";
    otag  = !valid ? "R8" : !chkd ? "R4" : op[1] ? "R6" : "R5";
    chk(rtag, 64'(s_res), 64'(eres));
    chk(otag, 64'(s_ovf), 64'(eovf));
    chk(valid ? "R7" : "R8", 64'(s_wr), 64'(ewr));
  endtask

  task automatic wide_vec(input string tag, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] imm,
                          input logic [31:0] eres, input bit eovf);
    @(posedge clk);
    w_op = op; w_a = a; w_b = b; w_imm = imm; w_req = 1'b1;
    @(negedge clk);
    chk(tag, 64'(w_res), 64'(eres));
    chk(tag, 64'(w_ovf), 64'(eovf));
    chk("R7", 64'(w_wr), 64'(!eovf));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all-zero inputs, add of zeros
    chk("R1", 64'(s_res), 64'd0);
    chk("R4", 64'(s_ovf), 64'd0);
    chk("R7", 64'(s_wr), 64'd0);
    rst = 1'b0;

    // exhaustive register forms and undefined opcodes
    for (int op = 0; op < 8; op++) begin
      if (op == 4 || op == 5) continue;
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          small_vec(op, a, b, (a + b) & 7, bit'((a ^ b) & 1));
    end
    // exhaustive immediate forms; rs_b varied to show it has no effect (R3)
    for (int op = 4; op < 6; op++)
      for (int a = 0; a < 16; a++)
        for (int imm = 0; imm < 8; imm++)
          small_vec(op, a, (a * 5 + imm * 3) & 15, imm, bit'(imm & 1) | bit'(a == 7));

    // 32-bit directed corners
    wide_vec("R5", 3'd0, 32'h7fffffff, 32'd1, 16'h0, 32'h80000000, 1'b1);
    wide_vec("R9", 3'd1, 32'h7fffffff, 32'd1, 16'h0, 32'h80000000, 1'b0);
    wide_vec("R6", 3'd2, 32'h80000000, 32'd1, 16'h0, 32'h7fffffff, 1'b1);
    wide_vec("R9", 3'd3, 32'h80000000, 32'd1, 16'h0, 32'h7fffffff, 1'b0);
    wide_vec("R6", 3'd2, 32'h0, 32'h80000000, 16'h0, 32'h80000000, 1'b1);
    wide_vec("R2", 3'd3, 32'h0, 32'd1, 16'h0, 32'hffffffff, 1'b0);
    wide_vec("R3", 3'd4, 32'd5, 32'h12345678, 16'hfff6, 32'hfffffffb, 1'b0);
    wide_vec("R5", 3'd4, 32'h80000000, 32'h0, 16'h8000, 32'h7fff8000, 1'b1);
    wide_vec("R4", 3'd5, 32'h80000000, 32'h0, 16'h8000, 32'h7fff8000, 1'b0);
    wide_vec("R1", 3'd0, 32'hffffffff, 32'd1, 16'h0, 32'h0, 1'b0);
    finish_run();
  end

endmodule